// File: doc/BRIEF.md
# Three-Deep Receive Message Queue

This block queues accepted receive messages for software. A message arrives on the write side as one fixed-width word (identifier and payload packed together), marked by a one-cycle valid strobe. It is stored in one of three slots. The output mailbox always shows the oldest stored message. Software reads the mailbox and pulses a release strobe to free it, and the next-oldest message then moves to the output.

A 2-bit count reports how many messages wait. A full flag and a sticky overrun flag report the queue's state. When a message arrives while all three slots hold data and no release happens in the same cycle, one message is lost. A configuration bit selects which one: with the lock bit clear, the newest stored entry is replaced; with the lock bit set, the incoming message is dropped. Three interrupt enables feed one combined interrupt line.

Top module: `rx_msg_queue`

## Requirements
- R1: After synchronous reset, the count is 00, the full and overrun flags are 0, the interrupt line is 0 and the mailbox reads all zeros.
- R2: A valid message stored while fewer than three are held raises the count by one (00 empty, 01, 10, 11 = three held), and the mailbox keeps showing the oldest message. While the count is 00 the mailbox reads zero.
- R3: A release strobe with the count nonzero lowers the count by one, and the next-oldest message appears in the mailbox on the following cycle.
- R4: A valid message and a release in the same cycle leave the count unchanged, and the queue stays in first-in first-out order. At count 01, the new message is the one shown afterwards.
- R5: A release strobe while the count is 00 is ignored: the count stays 00 and later messages are queued normally.
- R6: A valid message with the count at 11 and no release in the same cycle sets the overrun flag and leaves the count at 11.
- R7: With the lock bit at 0, an overrunning message replaces the most recently stored entry, and the older two entries are unaffected.
- R8: With the lock bit at 1, an overrunning message is dropped, and the three stored messages are unaffected.
- R9: The full flag sets when a store brings the count to 11. It clears when a release brings the count below 11, or when bit 0 of the clear strobe is written as 1.
- R10: The overrun flag stays set until bit 1 of the clear strobe is written as 1.
- R11: The interrupt line is the OR of three terms: pending-enable AND count nonzero, full-enable AND full flag, overrun-enable AND overrun flag.
- R12: A valid message together with a release at count 11 is stored normally: no overrun, and the count stays 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle strobe: an accepted message is presented |
| wr_msg | input | MSG_W | Accepted message word |
| rel_strobe | input | 1 | Software release of the output mailbox |
| lock_mode | input | 1 | 1: drop message on overrun; 0: replace newest entry |
| ie_pend | input | 1 | Interrupt enable for count nonzero |
| ie_full | input | 1 | Interrupt enable for full flag |
| ie_ovr | input | 1 | Interrupt enable for overrun flag |
| clr_flags | input | 2 | Write-one-to-clear: bit 0 full, bit 1 overrun |
| pend_cnt | output | 2 | Number of stored messages |
| full_flag | output | 1 | Full flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| mbox_out | output | MSG_W | Oldest stored message, zero when empty |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong read or write pointer shows up as the wrong word in the mailbox. For a read pointer, this appears on the cycle after the next release. For a write pointer, it appears once the corrupted slot reaches the head, at most three releases later. A wrong count appears as soon as the next cycle: either at the count port, as a mismatch between the full flag and the count, or as a false overrun. The directed sequences therefore drain the queue after each scenario and compare every word in order. This covers the overwrite and drop policies, as well as releases that happen at the same time as a store.

// File: rtl/rx_msg_queue_pkg.sv
package rx_msg_queue_pkg;

    localparam int RXQ_DEPTH = 3;
    localparam int PTR_W     = 2;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [1:0] {
        PEND_NONE  = 2'b00,
        PEND_ONE   = 2'b01,
        PEND_TWO   = 2'b10,
        PEND_THREE = 2'b11
    } pend_e;

    typedef struct packed {
        logic store;
        logic overrun;
        logic release_ok;
        logic full_set;
        logic below_three;
        logic nonzero;
    } rxq_evt_t;

    function automatic ptr_t ptr_inc(input ptr_t p);
        return (p == ptr_t'(RXQ_DEPTH - 1)) ? ptr_t'(0) : p + ptr_t'(1);
    endfunction

    function automatic ptr_t ptr_dec(input ptr_t p);
        return (p == ptr_t'(0)) ? ptr_t'(RXQ_DEPTH - 1) : p - ptr_t'(1);
    endfunction

    function automatic pend_e pend_up(input pend_e c);
        case (c)
            PEND_NONE: return PEND_ONE;
            PEND_ONE:  return PEND_TWO;
            default:   return PEND_THREE;
        endcase
    endfunction

    function automatic pend_e pend_down(input pend_e c);
        case (c)
            PEND_THREE: return PEND_TWO;
            PEND_TWO:   return PEND_ONE;
            default:    return PEND_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rx_msg_queue_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_valid,
    input  logic     rel_strobe,
    input  logic     lock_mode,
    output pend_e    cnt_q,
    output ptr_t     rd_ptr,
    output logic     slot_we,
    output ptr_t     slot_idx,
    output rxq_evt_t evt
);

    ptr_t  wr_ptr;
    pend_e cnt_nxt;
    logic  do_rel, at_full, do_store, do_ovr, do_overwrite;

    always_comb begin
        do_rel       = rel_strobe && (cnt_q != PEND_NONE);
        at_full      = (cnt_q == PEND_THREE);
        do_store     = wr_valid && (!at_full || do_rel);
        do_ovr       = wr_valid && at_full && !do_rel;
        do_overwrite = do_ovr && !lock_mode;
        slot_we      = do_store || do_overwrite;
        slot_idx     = do_overwrite ? ptr_dec(wr_ptr) : wr_ptr;
        case ({do_store, do_rel})
            2'b10:   cnt_nxt = pend_up(cnt_q);
            2'b01:   cnt_nxt = pend_down(cnt_q);
            default: cnt_nxt = cnt_q;
        endcase
        evt.store       = do_store;
        evt.overrun     = do_ovr;
        evt.release_ok  = do_rel;
        evt.full_set    = do_store && (cnt_nxt == PEND_THREE);
        evt.below_three = (cnt_nxt != PEND_THREE);
        evt.nonzero     = (cnt_q != PEND_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= PEND_NONE;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (do_store) wr_ptr <= ptr_inc(wr_ptr);
            if (do_rel)   rd_ptr <= ptr_inc(rd_ptr);
        end
    end

    a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !rel_strobe && cnt_q != PEND_THREE) |=> cnt_q == pend_up($past(cnt_q)));

    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (rel_strobe && !wr_valid && cnt_q != PEND_NONE) |=> cnt_q == pend_down($past(cnt_q)));

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (rel_strobe && !wr_valid && cnt_q == PEND_NONE) |=> cnt_q == PEND_NONE);

    a_r4_simul_hold: assert property (@(posedge clk) disable iff (rst)
        (rel_strobe && wr_valid && cnt_q != PEND_NONE) |=> $stable(cnt_q));

    a_r8_lock_no_write: assert property (@(posedge clk) disable iff (rst)
        (lock_mode && wr_valid && !rel_strobe && cnt_q == PEND_THREE) |-> !slot_we);

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rx_msg_queue_pkg::*;
#(
    parameter int MSG_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  ptr_t             widx,
    input  logic [MSG_W-1:0] wdata,
    input  ptr_t             ridx,
    input  logic             show,
    output logic [MSG_W-1:0] rdata
);

    logic [MSG_W-1:0] slots [RXQ_DEPTH];

    for (genvar i = 0; i < RXQ_DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                             slots[i] <= '0;
            else if (we && widx == ptr_t'(i))    slots[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < RXQ_DEPTH; k++) begin
            if (show && ridx == ptr_t'(k)) rdata = slots[k];
        end
    end

    a_r2_index_in_range: assert property (@(posedge clk) disable iff (rst)
        we |-> widx < ptr_t'(RXQ_DEPTH));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rx_msg_queue_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rxq_evt_t evt,
    input  logic     ie_pend,
    input  logic     ie_full,
    input  logic     ie_ovr,
    input  logic [1:0] clr_flags,
    output logic     full_q,
    output logic     ovr_q,
    output logic     irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            full_q <= evt.full_set || (full_q && !clr_flags[0] && !evt.below_three);
            ovr_q  <= evt.overrun  || (ovr_q && !clr_flags[1]);
        end
    end

    assign irq = (ie_pend && evt.nonzero) || (ie_full && full_q) || (ie_ovr && ovr_q);

    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !clr_flags[1]) |=> ovr_q);

    a_r10_ovr_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_flags[1] && !evt.overrun) |=> !ovr_q);

    a_r9_full_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_flags[0] && !evt.full_set) |=> !full_q);

endmodule

// File: rtl/rx_msg_queue.sv
module rx_msg_queue
    import rx_msg_queue_pkg::*;
#(
    parameter int MSG_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [MSG_W-1:0] wr_msg,
    input  logic             rel_strobe,
    input  logic             lock_mode,
    input  logic             ie_pend,
    input  logic             ie_full,
    input  logic             ie_ovr,
    input  logic [1:0]       clr_flags,
    output logic [1:0]       pend_cnt,
    output logic             full_flag,
    output logic             ovr_flag,
    output logic [MSG_W-1:0] mbox_out,
    output logic             irq
);

    pend_e    cnt_q;
    ptr_t     rd_ptr, slot_idx;
    logic     slot_we;
    rxq_evt_t evt;

    rxq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .rel_strobe (rel_strobe),
        .lock_mode  (lock_mode),
        .cnt_q      (cnt_q),
        .rd_ptr     (rd_ptr),
        .slot_we    (slot_we),
        .slot_idx   (slot_idx),
        .evt        (evt)
    );

    rxq_store #(.MSG_W(MSG_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (slot_we),
        .widx  (slot_idx),
        .wdata (wr_msg),
        .ridx  (rd_ptr),
        .show  (evt.nonzero),
        .rdata (mbox_out)
    );

    rxq_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .ie_pend   (ie_pend),
        .ie_full   (ie_full),
        .ie_ovr    (ie_ovr),
        .clr_flags (clr_flags),
        .full_q    (full_flag),
        .ovr_q     (ovr_flag),
        .irq       (irq)
    );

    assign pend_cnt = cnt_q;

    a_r9_full_means_three: assert property (@(posedge clk) disable iff (rst)
        full_flag |-> pend_cnt == 2'b11);

    a_r6_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !rel_strobe && pend_cnt == 2'b11) |=> ovr_flag && pend_cnt == 2'b11);

    a_r12_no_false_overrun: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && rel_strobe && !ovr_flag && clr_flags == 2'b00) |=> !ovr_flag);

    a_r2_empty_mailbox_zero: assert property (@(posedge clk) disable iff (rst)
        (pend_cnt == 2'b00) |-> mbox_out == '0);

endmodule

// File: tb/rx_msg_queue_tb.sv
module rx_msg_queue_tb;

    localparam int MSG_W = 64;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_valid, rel_strobe, lock_mode, ie_pend, ie_full, ie_ovr;
    logic [MSG_W-1:0] wr_msg;
    logic [1:0]       clr_flags;
    logic [1:0]       pend_cnt;
    logic             full_flag, ovr_flag, irq;
    logic [MSG_W-1:0] mbox_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rx_msg_queue #(.MSG_W(MSG_W)) u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_msg(wr_msg),
        .rel_strobe(rel_strobe), .lock_mode(lock_mode), .ie_pend(ie_pend),
        .ie_full(ie_full), .ie_ovr(ie_ovr), .clr_flags(clr_flags),
        .pend_cnt(pend_cnt), .full_flag(full_flag), .ovr_flag(ovr_flag),
        .mbox_out(mbox_out), .irq(irq)
    );

    function automatic logic [MSG_W-1:0] msg(input int k);
        return 64'hC0DE_0000_0000_0000 | 64'(k * 32'h0101_0011);
    endfunction

    task automatic chk(input string req, input logic [MSG_W-1:0] act, input logic [MSG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: inputs held across a rising edge, then released; outputs settled on return
    task automatic cyc(input logic wv, input int k, input logic r, input logic [1:0] c);
        wr_valid   = wv;
        wr_msg     = wv ? msg(k) : '0;
        rel_strobe = r;
        clr_flags  = c;
        @(posedge clk);
        #2;
        wr_valid   = 1'b0;
        wr_msg     = '0;
        rel_strobe = 1'b0;
        clr_flags  = 2'b00;
    endtask

    task automatic pop_expect(input string req, input int k);
        chk(req, mbox_out, msg(k));
        cyc(1'b0, 0, 1'b1, 2'b00);
    endtask

    task automatic t_reset;
        chk("R1 count", 64'(pend_cnt), 64'(0));
        chk("R1 full", 64'(full_flag), 64'(0));
        chk("R1 ovr", 64'(ovr_flag), 64'(0));
        chk("R1 irq", 64'(irq), 64'(0));
        chk("R1 mbox", mbox_out, '0);
    endtask

    task automatic t_fill_and_drain;
        cyc(1'b1, 1, 1'b0, 2'b00);
        chk("R2 count 01", 64'(pend_cnt), 64'(1));
        chk("R2 head msg1", mbox_out, msg(1));
        chk("R11 irq off when disabled", 64'(irq), 64'(0));
        ie_pend = 1'b1; #1;
        chk("R11 pending irq", 64'(irq), 64'(1));
        cyc(1'b1, 2, 1'b0, 2'b00);
        chk("R2 count 10", 64'(pend_cnt), 64'(2));
        chk("R9 not full at 10", 64'(full_flag), 64'(0));
        cyc(1'b1, 3, 1'b0, 2'b00);
        chk("R2 count 11", 64'(pend_cnt), 64'(3));
        chk("R2 head still msg1", mbox_out, msg(1));
        chk("R9 full set", 64'(full_flag), 64'(1));
        cyc(1'b0, 0, 1'b1, 2'b00);
        chk("R3 count 10", 64'(pend_cnt), 64'(2));
        chk("R3 head msg2", mbox_out, msg(2));
        chk("R9 full auto clear", 64'(full_flag), 64'(0));
        cyc(1'b0, 0, 1'b1, 2'b00);
        chk("R3 head msg3", mbox_out, msg(3));
        cyc(1'b1, 4, 1'b1, 2'b00);
        chk("R4 count stays 01", 64'(pend_cnt), 64'(1));
        chk("R4 new msg visible", mbox_out, msg(4));
        cyc(1'b0, 0, 1'b1, 2'b00);
        chk("R3 empty count", 64'(pend_cnt), 64'(0));
        chk("R2 empty mbox zero", mbox_out, '0);
        chk("R11 pending irq drops", 64'(irq), 64'(0));
    endtask

    task automatic t_empty_release;
        cyc(1'b0, 0, 1'b1, 2'b00);
        chk("R5 count stays 00", 64'(pend_cnt), 64'(0));
        cyc(1'b1, 5, 1'b0, 2'b00);
        chk("R5 count 01 after", 64'(pend_cnt), 64'(1));
        chk("R5 head msg5", mbox_out, msg(5));
        cyc(1'b1, 6, 1'b0, 2'b00);
        pop_expect("R5 order msg5", 5);
        pop_expect("R5 order msg6", 6);
        chk("R5 drained", 64'(pend_cnt), 64'(0));
    endtask

    task automatic t_overwrite;
        lock_mode = 1'b0;
        cyc(1'b1, 7, 1'b0, 2'b00);
        cyc(1'b1, 8, 1'b0, 2'b00);
        cyc(1'b1, 9, 1'b0, 2'b00);
        chk("R6 no overrun yet", 64'(ovr_flag), 64'(0));
        cyc(1'b1, 10, 1'b0, 2'b00);
        chk("R6 overrun set", 64'(ovr_flag), 64'(1));
        chk("R6 count stays 11", 64'(pend_cnt), 64'(3));
        ie_ovr = 1'b1; ie_pend = 1'b0; #1;
        chk("R11 overrun irq", 64'(irq), 64'(1));
        ie_ovr = 1'b0;
        pop_expect("R7 oldest kept", 7);
        pop_expect("R7 second kept", 8);
        chk("R10 overrun sticky", 64'(ovr_flag), 64'(1));
        pop_expect("R7 newest replaced", 10);
        chk("R7 drained", 64'(pend_cnt), 64'(0));
    endtask

    task automatic t_lock;
        cyc(1'b0, 0, 1'b0, 2'b10);
        chk("R10 overrun cleared", 64'(ovr_flag), 64'(0));
        lock_mode = 1'b1;
        cyc(1'b1, 11, 1'b0, 2'b00);
        cyc(1'b1, 12, 1'b0, 2'b00);
        cyc(1'b1, 13, 1'b0, 2'b00);
        cyc(1'b1, 14, 1'b0, 2'b00);
        chk("R6 overrun in lock", 64'(ovr_flag), 64'(1));
        pop_expect("R8 keep msg11", 11);
        pop_expect("R8 keep msg12", 12);
        pop_expect("R8 keep msg13", 13);
        chk("R8 drained", 64'(pend_cnt), 64'(0));
        cyc(1'b0, 0, 1'b0, 2'b10);
    endtask

    task automatic t_full_clear_and_simul;
        lock_mode = 1'b0;
        cyc(1'b1, 15, 1'b0, 2'b00);
        cyc(1'b1, 16, 1'b0, 2'b00);
        cyc(1'b1, 17, 1'b0, 2'b00);
        ie_full = 1'b1; #1;
        chk("R11 full irq", 64'(irq), 64'(1));
        cyc(1'b0, 0, 1'b0, 2'b01);
        chk("R9 full w1c", 64'(full_flag), 64'(0));
        chk("R9 count kept", 64'(pend_cnt), 64'(3));
        chk("R11 irq off after clear", 64'(irq), 64'(0));
        ie_full = 1'b0;
        cyc(1'b1, 18, 1'b1, 2'b00);
        chk("R12 no overrun", 64'(ovr_flag), 64'(0));
        chk("R12 count 11", 64'(pend_cnt), 64'(3));
        chk("R12 head msg16", mbox_out, msg(16));
        pop_expect("R12 order msg16", 16);
        pop_expect("R12 order msg17", 17);
        pop_expect("R12 order msg18", 18);
        chk("R12 drained", 64'(pend_cnt), 64'(0));
    endtask

    initial begin
        rst = 1'b1;
        wr_valid = 1'b0; wr_msg = '0; rel_strobe = 1'b0; clr_flags = 2'b00;
        lock_mode = 1'b0; ie_pend = 1'b0; ie_full = 1'b0; ie_ovr = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        t_reset();
        t_fill_and_drain();
        t_empty_release();
        t_overwrite();
        t_lock();
        t_full_clear_and_simul();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule